// File: doc/BRIEF.md
# Receive Frame Status Tracker

This block sits beside the receive path of an infrared serial link. For every byte that the receive state machine wants to store, it decides whether the byte may enter the receive FIFO. It counts the bytes that each frame delivers. When a frame closes, it files a record for that frame into a small status queue. Each record holds the frame length and the error flags that came with the end of the frame. The host reads the record at the head of the queue through two length views and one status view. Sampling the status view with a read strobe retires the record.

A write attempt into a full receive FIFO is an overrun. An overrun raises an interrupt and files a record for the truncated frame with its overrun flag set. It then locks reception, so the rest of that frame and any later traffic are thrown away. To recover, the host must first flush the receive FIFO and then read the resume register. If the status queue is already full when a record arrives, the record is lost and a sticky overflow flag is raised.

Top module: `rx_frame_status`

## Requirements
- R1: `byte_wr` is 1 in the same cycle that `byte_valid` is 1, `rxfifo_full` is 0 and reception is not locked. In every other cycle it is 0.
- R2: When `byte_valid` is 1, `rxfifo_full` is 1 and reception is not locked, the next cycle shows `ovr_irq` = 1 and `rx_locked` = 1. `byte_wr` stays 0 for that byte.
- R3: An overrun files one record at once. Its length is the number of bytes of the current frame accepted so far, and its status is 4'b1000 (bit 3 = overrun, no other error bit).
- R4: While `rx_locked` is 1, `byte_valid` and `frame_end` have no effect. No byte is written, no record is filed and the length count does not move.
- R5: `rx_locked` clears only on a `rd_resume` pulse that comes at least one cycle after a `rxfifo_reset` pulse seen while locked. A resume read without a prior flush leaves the lock set. Any `rd_resume` pulse clears `ovr_irq` (an overrun in the same cycle wins).
- R6: A `frame_end` pulse while not locked, and with no overrun in that cycle, files a record. The record length counts an accepted byte in the same cycle, and its status bits are bit0 = `err_crc`, bit1 = `err_abort`, bit2 = `err_long`, bit3 = 0. The length count then restarts at zero.
- R7: The record length is 12 bits, shown as `len_lo` = bits 7:0 and `len_hi` = bits 11:8. The count saturates at 4095.
- R8: The status queue holds 8 records in arrival order. A `rd_stat` pulse retires the head record at the clock edge. The length and status views always show the current head.
- R9: A record that arrives while the queue holds 8 records, with no retire in the same cycle, is discarded and sets `stat_ovf`. `stat_ovf` stays set until a `rd_resume` pulse in a cycle with no new discard.
- R10: With the queue empty, `len_lo`, `len_hi` and `stat` read as zero. A `rd_stat` pulse then changes nothing, and the next record filed appears at the head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_valid | input | 1 | Receive state machine offers a byte |
| rxfifo_full | input | 1 | Receive FIFO is full |
| frame_end | input | 1 | Current frame is complete |
| err_crc | input | 1 | CRC error flag, valid with frame_end |
| err_abort | input | 1 | Abort flag, valid with frame_end |
| err_long | input | 1 | Frame-too-long flag, valid with frame_end |
| rxfifo_reset | input | 1 | Host flushes the receive FIFO |
| rd_resume | input | 1 | Host reads the resume register |
| rd_stat | input | 1 | Host reads the status view (retires the head record) |
| byte_wr | output | 1 | Write enable into the receive FIFO |
| len_lo | output | 8 | Head record length, bits 7:0 |
| len_hi | output | 4 | Head record length, bits 11:8 |
| stat | output | 4 | Head record error flags |
| stat_ovf | output | 1 | Sticky status-queue overflow |
| ovr_irq | output | 1 | Overrun interrupt bit |
| rx_locked | output | 1 | Reception is disabled after an overrun |

## Verification
A wrong queue pointer or count shows on the very next host read. The status or length views then return a record out of order, a stale record, or zero where a record was expected. A lock flag that is stuck or cleared too early shows in the same cycle as a wrong `byte_wr` for the next offered byte. A wrong length counter shows only when its frame closes, so it can stay hidden for a whole frame. It is exposed at the first record read after that frame ends.

// File: rtl/rfs_pkg.sv
`timescale 1ns/1ps
package rfs_pkg;
  localparam int LEN_W = 12;
  localparam int ERR_W = 4;
  localparam int LO_W  = 8;
  localparam int HI_W  = LEN_W - LO_W;

  localparam int ERR_CRC   = 0;
  localparam int ERR_ABORT = 1;
  localparam int ERR_LONG  = 2;
  localparam int ERR_OVR   = 3;

  typedef struct packed {
    logic [ERR_W-1:0] err;
    logic [LEN_W-1:0] len;
  } rfs_rec_t;

  localparam int REC_W = ERR_W + LEN_W;
endpackage

// File: rtl/rfs_len_track.sv
`timescale 1ns/1ps
module rfs_len_track #(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic             clr,
  output logic [LEN_W-1:0] frame_len
);
  localparam logic [LEN_W-1:0] LEN_MAX = {LEN_W{1'b1}};

  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] cnt_d;
  logic [LEN_W-1:0] cnt_inc;

  always_comb begin
    cnt_inc   = (cnt_q == LEN_MAX) ? LEN_MAX : cnt_q + 1'b1;
    frame_len = acc ? cnt_inc : cnt_q;
    cnt_d     = clr ? '0 : frame_len;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (acc || clr) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rfs_ovr_ctrl.sv
`timescale 1ns/1ps
module rfs_ovr_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic byte_valid,
  input  logic rxfifo_full,
  input  logic rxfifo_reset,
  input  logic rd_resume,
  output logic byte_wr,
  output logic ovr_evt,
  output logic locked,
  output logic irq
);
  logic locked_q, locked_d;
  logic flushed_q, flushed_d;
  logic irq_q, irq_d;
  logic upd;

  always_comb begin
    ovr_evt   = byte_valid & rxfifo_full & ~locked_q;
    byte_wr   = byte_valid & ~rxfifo_full & ~locked_q;
    locked_d  = locked_q;
    flushed_d = flushed_q;
    irq_d     = irq_q;
    if (ovr_evt) begin
      locked_d  = 1'b1;
      flushed_d = 1'b0;
      irq_d     = 1'b1;
    end else begin
      if (rd_resume) irq_d = 1'b0;
      if (locked_q) begin
        if (rd_resume && flushed_q) begin
          locked_d  = 1'b0;
          flushed_d = 1'b0;
        end else if (rxfifo_reset) begin
          flushed_d = 1'b1;
        end
      end
    end
    upd = ovr_evt | rd_resume | rxfifo_reset;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q  <= 1'b0;
      flushed_q <= 1'b0;
      irq_q     <= 1'b0;
    end else if (upd) begin
      locked_q  <= locked_d;
      flushed_q <= flushed_d;
      irq_q     <= irq_d;
    end
  end

  assign locked = locked_q;
  assign irq    = irq_q;
endmodule

// File: rtl/rfs_stat_fifo.sv
`timescale 1ns/1ps
module rfs_stat_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         drop
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] PTR_LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rd_ptr_q, rd_ptr_d;
  logic [PW-1:0] wr_ptr_q, wr_ptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          empty, full, pop_ok, push_ok;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    empty    = (cnt_q == '0);
    full     = (cnt_q == CNT_FULL);
    pop_ok   = pop & ~empty;
    push_ok  = push & (~full | pop_ok);
    drop     = push & full & ~pop_ok;
    rd_ptr_d = pop_ok  ? ptr_inc(rd_ptr_q) : rd_ptr_q;
    wr_ptr_d = push_ok ? ptr_inc(wr_ptr_q) : wr_ptr_q;
    cnt_d    = cnt_q;
    if (push_ok && !pop_ok)      cnt_d = cnt_q + 1'b1;
    else if (pop_ok && !push_ok) cnt_d = cnt_q - 1'b1;
    dout     = empty ? '0 : mem[rd_ptr_q];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (push_ok || pop_ok) begin
      rd_ptr_q <= rd_ptr_d;
      wr_ptr_q <= wr_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    logic wen;
    assign wen = push_ok && (wr_ptr_q == PW'(i));
    always_ff @(posedge clk) begin
      if (wen) mem[i] <= din;
    end
  end
endmodule

// File: rtl/rx_frame_status.sv
`timescale 1ns/1ps
module rx_frame_status
  import rfs_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            byte_valid,
  input  logic            rxfifo_full,
  input  logic            frame_end,
  input  logic            err_crc,
  input  logic            err_abort,
  input  logic            err_long,
  input  logic            rxfifo_reset,
  input  logic            rd_resume,
  input  logic            rd_stat,
  output logic            byte_wr,
  output logic [LO_W-1:0] len_lo,
  output logic [HI_W-1:0] len_hi,
  output logic [ERR_W-1:0] stat,
  output logic            stat_ovf,
  output logic            ovr_irq,
  output logic            rx_locked
);
  logic             ovr_evt, fe_evt, rec_push, rec_drop;
  logic [LEN_W-1:0] frame_len;
  rfs_rec_t         rec_in, rec_head;
  logic [REC_W-1:0] head_bits;
  logic             ovf_q, ovf_d;

  rfs_ovr_ctrl u_ovr (
    .clk          (clk),
    .rst_n        (rst_n),
    .byte_valid   (byte_valid),
    .rxfifo_full  (rxfifo_full),
    .rxfifo_reset (rxfifo_reset),
    .rd_resume    (rd_resume),
    .byte_wr      (byte_wr),
    .ovr_evt      (ovr_evt),
    .locked       (rx_locked),
    .irq          (ovr_irq)
  );

  always_comb begin
    fe_evt   = frame_end & ~rx_locked & ~ovr_evt;
    rec_push = fe_evt | ovr_evt;
    rec_in.len = frame_len;
    rec_in.err = '0;
    if (ovr_evt) begin
      rec_in.err[ERR_OVR] = 1'b1;
    end else begin
      rec_in.err[ERR_CRC]   = err_crc;
      rec_in.err[ERR_ABORT] = err_abort;
      rec_in.err[ERR_LONG]  = err_long;
    end
  end

  rfs_len_track #(.LEN_W(LEN_W)) u_len (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc       (byte_wr),
    .clr       (rec_push),
    .frame_len (frame_len)
  );

  rfs_stat_fifo #(.W(REC_W), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (rec_push),
    .pop   (rd_stat),
    .din   (rec_in),
    .dout  (head_bits),
    .drop  (rec_drop)
  );

  always_comb begin
    rec_head = rfs_rec_t'(head_bits);
    len_lo   = rec_head.len[LO_W-1:0];
    len_hi   = rec_head.len[LEN_W-1:LO_W];
    stat     = rec_head.err;
    ovf_d    = ovf_q;
    if (rec_drop)       ovf_d = 1'b1;
    else if (rd_resume) ovf_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_q <= 1'b0;
    else if (rec_drop || rd_resume) ovf_q <= ovf_d;
  end

  assign stat_ovf = ovf_q;
endmodule

// File: rtl/rfs_checker.sv
`timescale 1ns/1ps
module rfs_checker (
  input logic clk,
  input logic rst_n,
  input logic byte_valid,
  input logic rxfifo_full,
  input logic rd_resume,
  input logic byte_wr,
  input logic stat_ovf,
  input logic ovr_irq,
  input logic rx_locked
);
  AST_WR_NEEDS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    byte_wr |-> (byte_valid && !rxfifo_full)); // R1
  AST_OVR_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && rxfifo_full && !rx_locked) |=> (rx_locked && ovr_irq)); // R2
  AST_LOCK_BLOCKS_WR: assert property (@(posedge clk) disable iff (!rst_n)
    rx_locked |-> !byte_wr); // R4
  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_locked && !rd_resume) |=> rx_locked); // R5
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_ovf && !rd_resume) |=> stat_ovf); // R9
endmodule

bind rx_frame_status rfs_checker u_rfs_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .byte_valid  (byte_valid),
  .rxfifo_full (rxfifo_full),
  .rd_resume   (rd_resume),
  .byte_wr     (byte_wr),
  .stat_ovf    (stat_ovf),
  .ovr_irq     (ovr_irq),
  .rx_locked   (rx_locked)
);

// File: tb/rx_frame_status_bench.sv
`timescale 1ns/1ps
module rx_frame_status_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, byte_valid, rxfifo_full, frame_end, err_crc, err_abort, err_long;
  logic rxfifo_reset, rd_resume, rd_stat;
  logic byte_wr, stat_ovf, ovr_irq, rx_locked;
  logic [7:0] len_lo;
  logic [3:0] len_hi, stat;

  rx_frame_status u_rx_frame_status (.*);

  int n_chk = 0, n_fail = 0;
  logic [15:0] mq[$];
  int  mcnt;
  bit  mlock, mirq, mflush, movf;

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic idle_in();
    byte_valid = 0; rxfifo_full = 0; frame_end = 0; err_crc = 0; err_abort = 0;
    err_long = 0; rxfifo_reset = 0; rd_resume = 0; rd_stat = 0;
  endtask

  task automatic check_outs();
    chk("R1", "byte_wr", byte_wr, int'(byte_valid && !rxfifo_full && !mlock));
    chk("R7", "len_lo", len_lo, mq.size() ? int'(mq[0][7:0]) : 0);
    chk("R7", "len_hi", len_hi, mq.size() ? int'(mq[0][11:8]) : 0);
    chk("R8", "stat", stat, mq.size() ? int'(mq[0][15:12]) : 0);
    chk("R2", "ovr_irq", ovr_irq, int'(mirq));
    chk("R5", "rx_locked", rx_locked, int'(mlock));
    chk("R9", "stat_ovf", stat_ovf, int'(movf));
  endtask

  task automatic model_update();
    bit ovr, acc, fe, pop, drop;
    int flen;
    logic [15:0] rec, dummy;
    ovr  = byte_valid && rxfifo_full && !mlock;
    acc  = byte_valid && !rxfifo_full && !mlock;
    fe   = frame_end && !mlock && !ovr;
    flen = acc ? ((mcnt == 4095) ? 4095 : mcnt + 1) : mcnt;
    rec  = ovr ? {4'b1000, 12'(flen)} : {1'b0, err_long, err_abort, err_crc, 12'(flen)};
    pop  = rd_stat && (mq.size() > 0);
    drop = (ovr || fe) && (mq.size() == 8) && !pop;
    if (pop) dummy = mq.pop_front();
    if ((ovr || fe) && !drop) mq.push_back(rec);
    if (drop) movf = 1; else if (rd_resume) movf = 0;
    mcnt = (ovr || fe) ? 0 : flen;
    if (ovr) begin
      mlock = 1; mflush = 0; mirq = 1;
    end else begin
      if (rd_resume) mirq = 0;
      if (mlock) begin
        if (rd_resume && mflush) begin mlock = 0; mflush = 0; end
        else if (rxfifo_reset) mflush = 1;
      end
    end
  endtask

  task automatic step();
    #1 check_outs();
    @(posedge clk);
    model_update();
    #1;
  endtask

  task automatic send_frame(int nbytes, bit [2:0] errs);
    for (int i = 0; i < nbytes; i++) begin
      idle_in(); byte_valid = 1; step();
    end
    idle_in(); frame_end = 1; {err_long, err_abort, err_crc} = errs; step();
    idle_in();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  initial begin
    idle_in();
    rst_n = 0;
    mcnt = 0; mlock = 0; mirq = 0; mflush = 0; movf = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R10", "reset stat", stat, 0);
    chk("R2", "reset irq", ovr_irq, 0);
    chk("R5", "reset lock", rx_locked, 0);
    rst_n = 1;

    // R10: empty read returns zero and moves nothing
    rd_stat = 1; step(); idle_in();
    chk("R10", "empty len_lo", len_lo, 0);
    send_frame(5, 3'b001);
    chk("R6", "len after crc frame", len_lo, 5);
    chk("R6", "crc status", stat, 1);
    chk("R10", "record lands at head after empty read", len_lo, 5);
    rd_stat = 1; step(); idle_in();

    // R6: last byte in same cycle as frame_end, abort+long flags
    for (int i = 0; i < 2; i++) begin byte_valid = 1; step(); end
    byte_valid = 1; frame_end = 1; err_abort = 1; err_long = 1; step(); idle_in();
    chk("R6", "len includes closing byte", len_lo, 3);
    chk("R6", "abort+long status", stat, 6);
    rd_stat = 1; step(); idle_in();

    // R3, R4, R5: overrun
    for (int i = 0; i < 3; i++) begin byte_valid = 1; step(); end
    byte_valid = 1; rxfifo_full = 1; step(); idle_in();
    chk("R3", "overrun record length", len_lo, 3);
    chk("R3", "overrun record status", stat, 8);
    chk("R2", "irq after overrun", ovr_irq, 1);
    byte_valid = 1; #1 chk("R4", "no write while locked", byte_wr, 0); #0;
    step(); idle_in();
    frame_end = 1; step(); idle_in();
    rd_stat = 1; step(); idle_in();
    chk("R4", "no record filed while locked", stat, 0);
    rd_resume = 1; step(); idle_in();
    chk("R5", "resume without flush keeps lock", rx_locked, 1);
    chk("R5", "resume clears irq", ovr_irq, 0);
    rxfifo_reset = 1; step(); idle_in();
    rd_resume = 1; step(); idle_in();
    chk("R5", "flush then resume unlocks", rx_locked, 0);

    // R8, R9: fill queue, overflow, drain in order
    for (int k = 1; k <= 9; k++) send_frame(k, 3'b000);
    chk("R9", "overflow flag", stat_ovf, 1);
    for (int k = 1; k <= 8; k++) begin
      chk("R8", "fifo order", len_lo, k);
      rd_stat = 1; step(); idle_in();
    end
    chk("R10", "drained stat", stat, 0);
    rd_resume = 1; step(); idle_in();
    chk("R9", "resume clears overflow", stat_ovf, 0);

    // R7: saturation
    send_frame(4100, 3'b000);
    chk("R7", "saturated lo", len_lo, 255);
    chk("R7", "saturated hi", len_hi, 15);
    rd_stat = 1; step(); idle_in();

    // random traffic against the model
    void'($urandom(32'd20240601));
    for (int n = 0; n < 20000; n++) begin
      byte_valid   = ($urandom % 3) != 0;
      rxfifo_full  = ($urandom % 24) == 0;
      frame_end    = ($urandom % 10) == 0;
      err_crc      = $urandom % 2;
      err_abort    = ($urandom % 4) == 0;
      err_long     = ($urandom % 4) == 0;
      rxfifo_reset = ($urandom % 15) == 0;
      rd_resume    = ($urandom % 18) == 0;
      rd_stat      = ($urandom % 7) == 0;
      step();
    end
    idle_in();
    step();
    summary();
  end
endmodule